// File: doc/BRIEF.md
# Double-Buffered Sample Capture Controller

This block steers a continuous stream of stereo audio samples into two memory regions used alternately. Software programs a start address for each region and one common region length, then turns capture on. Each accepted sample becomes one memory write. Its address is the start address of the region currently being filled, plus a running byte offset. When a region is full, the block marks it full and carries on in the other region. No sample is lost at the switch.

Software empties a full region and hands it back through a write-one acknowledge for that region. If the block must switch into a region that has not yet been handed back, it raises a sticky overrun flag. It then discards incoming samples until that region is acknowledged. The two full flags and the overrun flag drive one level-sensitive interrupt line, each through its own enable. The register port is a simple single-cycle write strobe with a combinational read.

Top module: `pp_capture_ctrl`

## Requirements
- R1: After reset, the status word reads 1: region one is active, both full flags are clear and overrun is clear. The control register reads 0 and `irq_o` is low.
- R2: The two region start addresses and the region length always read back with their low six bits zero, whatever value was written.
- R3: While the enable bit is 0, no memory write is issued, whatever arrives at the sample input.
- R4: Each accepted sample produces one memory write in the same cycle. Its address is the active start address plus the offset, and the offset then grows by 4 bytes. Capture begins in region one at offset 0.
- R5: When an accepted sample brings offset+4 to the length or beyond, three things happen at the clock edge: the active region's full flag sets, the active selection toggles, and the offset returns to 0. The next sample goes to the other region's start address.
- R6: `irq_o` is high exactly while at least one of these holds: region-one full with its enable, region-two full with its enable, or overrun with its enable.
- R7: The acknowledge for a region clears that region's full flag at the next clock edge. If that region fills in the same cycle, the flag sets instead.
- R8: Overrun sets when a switch lands in a region whose full flag is still set and is not being acknowledged in that cycle. The two region acknowledges leave it unchanged. Only the overrun acknowledge clears it; a same-cycle set wins.
- R9: While the active region's full flag is set, samples are dropped and no memory write is issued. Capture resumes in that region at offset 0 once it is acknowledged.
- R10: Clearing the enable bit resets the offset to 0 at the next edge. The full flags, overrun and the active selection keep their values.
- R11: Writing the soft-reset bit returns every register, flag, the offset and the active selection to their reset values at the next edge.
- R12: Register map, selected by `reg_addr_i`:
  - 0: control. Bit 0 enable, bit 1 region-one interrupt enable, bit 2 region-two interrupt enable, bit 3 overrun interrupt enable. Bits 4, 5, 6 and 7 are write-one strobes that read as 0: bit 4 acknowledges region one, bit 5 acknowledges region two, bit 6 acknowledges overrun, bit 7 is soft reset.
  - 1: region-one start address.
  - 2: region-two start address.
  - 3: length.
  - 4: status. Bit 0 region one active, bit 1 region-one full, bit 2 region-two full, bit 3 overrun.
  - Other addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register select |
| reg_wdata_i | input | AW | Register write data |
| reg_rdata_o | output | AW | Register read data (combinational) |
| smp_valid_i | input | 1 | A sample is present this cycle |
| smp_data_i | input | SW | Packed stereo sample |
| mem_we_o | output | 1 | Memory write request |
| mem_addr_o | output | AW | Memory byte address |
| mem_wdata_o | output | SW | Memory write data |
| irq_o | output | 1 | Level-sensitive interrupt request |

## Verification
The bench builds the block with its defaults: 32-bit addresses, 32-bit samples, a 4-byte step and 64-byte alignment. With a programmed length of 64 bytes, one region holds only 16 samples. That small size puts several fills, a switch into an unacknowledged region, the dropped-sample phase and the resume within a few hundred cycles. It also makes room for the corners: a fill and an acknowledge of the same region in one cycle, and an enable drop in the middle of a region.

// File: rtl/pp_capture_pkg.sv
package pp_capture_pkg;

  localparam int unsigned REG_SEL_W = 3;

  typedef enum logic [REG_SEL_W-1:0] {
    SEL_CTRL  = 3'd0,
    SEL_BASE1 = 3'd1,
    SEL_BASE2 = 3'd2,
    SEL_SIZE  = 3'd3,
    SEL_STAT  = 3'd4
  } reg_sel_e;

  // strobe bit positions in the control word
  localparam int unsigned BIT_ACK1  = 4;
  localparam int unsigned BIT_ACK2  = 5;
  localparam int unsigned BIT_ACKOV = 6;
  localparam int unsigned BIT_SRST  = 7;

  typedef struct packed {
    logic ien_ovr;
    logic ien2;
    logic ien1;
    logic en;
  } ctrl_t;

  typedef struct packed {
    logic srst;
    logic ack_ovr;
    logic ack2;
    logic ack1;
  } strb_t;

  typedef struct packed {
    logic ovr;
    logic full2;
    logic full1;
    logic act1;
  } stat_t;

endpackage

// File: rtl/pp_regs.sv
module pp_regs
  import pp_capture_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned ALIGN_LSB = 6
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [REG_SEL_W-1:0] addr_i,
  input  logic [AW-1:0]        wdata_i,
  input  stat_t                stat_i,
  output logic [AW-1:0]        rdata_o,
  output ctrl_t                ctrl_o,
  output strb_t                strb_o,
  output logic [AW-1:0]        base1_o,
  output logic [AW-1:0]        base2_o,
  output logic [AW-1:0]        size_o
);

  localparam int unsigned HI_W = AW - ALIGN_LSB;

  ctrl_t           ctrl_q;
  logic [HI_W-1:0] base1_q, base2_q, size_q;
  logic            ctrl_wr;

  assign ctrl_wr = we_i && (addr_i == SEL_CTRL);

  assign strb_o.ack1    = ctrl_wr && wdata_i[BIT_ACK1];
  assign strb_o.ack2    = ctrl_wr && wdata_i[BIT_ACK2];
  assign strb_o.ack_ovr = ctrl_wr && wdata_i[BIT_ACKOV];
  assign strb_o.srst    = ctrl_wr && wdata_i[BIT_SRST];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      base1_q <= '0;
      base2_q <= '0;
      size_q  <= '0;
    end else if (strb_o.srst) begin
      ctrl_q  <= '0;
      base1_q <= '0;
      base2_q <= '0;
      size_q  <= '0;
    end else if (we_i) begin
      unique case (addr_i)
        SEL_CTRL:  ctrl_q  <= ctrl_t'(wdata_i[3:0]);
        SEL_BASE1: base1_q <= wdata_i[AW-1:ALIGN_LSB];
        SEL_BASE2: base2_q <= wdata_i[AW-1:ALIGN_LSB];
        SEL_SIZE:  size_q  <= wdata_i[AW-1:ALIGN_LSB];
        default: ;
      endcase
    end
  end

  assign ctrl_o  = ctrl_q;
  assign base1_o = {base1_q, {ALIGN_LSB{1'b0}}};
  assign base2_o = {base2_q, {ALIGN_LSB{1'b0}}};
  assign size_o  = {size_q, {ALIGN_LSB{1'b0}}};

  always_comb begin
    unique case (addr_i)
      SEL_CTRL:  rdata_o = AW'(ctrl_q);
      SEL_BASE1: rdata_o = base1_o;
      SEL_BASE2: rdata_o = base2_o;
      SEL_SIZE:  rdata_o = size_o;
      SEL_STAT:  rdata_o = AW'(stat_i);
      default:   rdata_o = '0;
    endcase
  end

  AST_STROBE_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == SEL_CTRL) |-> (rdata_o[7:4] == 4'b0)); // R12

endmodule

// File: rtl/pp_addr_gen.sv
module pp_addr_gen #(
  parameter int unsigned AW   = 32,
  parameter int unsigned STEP = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          srst_i,
  input  logic          en_i,
  input  logic          accept_i,
  input  logic [AW-1:0] size_i,
  output logic [AW-1:0] offset_o,
  output logic          wrap_o
);

  logic [AW-1:0] offset_q, offset_nxt;

  assign offset_nxt = offset_q + AW'(STEP);
  assign wrap_o     = accept_i && (offset_nxt >= size_i);
  assign offset_o   = offset_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            offset_q <= '0;
    else if (srst_i)        offset_q <= '0;
    else if (!en_i)         offset_q <= '0;
    else if (wrap_o)        offset_q <= '0;
    else if (accept_i)      offset_q <= offset_nxt;
  end

  AST_IDLE_OFFSET_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (offset_o == '0)); // R10

  AST_OFFSET_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && accept_i && !wrap_o && !srst_i) |=> (offset_o == $past(offset_o) + AW'(STEP))); // R4

endmodule

// File: rtl/pp_flags.sv
module pp_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic srst_i,
  input  logic wrap_i,
  input  logic ack1_i,
  input  logic ack2_i,
  input  logic ack_ovr_i,
  input  logic ien1_i,
  input  logic ien2_i,
  input  logic ien_ovr_i,
  output logic act1_o,
  output logic [1:0] full_o,
  output logic ovr_o,
  output logic stall_o,
  output logic irq_o
);

  localparam int unsigned NBUF = 2;

  logic            sel_q;   // 0: region one filling
  logic [NBUF-1:0] full_q;
  logic [NBUF-1:0] ack_v;
  logic [NBUF-1:0] ien_v;
  logic            ovr_q;

  assign ack_v = {ack2_i, ack1_i};
  assign ien_v = {ien2_i, ien1_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sel_q <= 1'b0;
    else if (srst_i) sel_q <= 1'b0;
    else if (wrap_i) sel_q <= ~sel_q;
  end

  for (genvar i = 0; i < NBUF; i++) begin : g_full
    logic set_c;
    assign set_c = wrap_i && (sel_q == 1'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       full_q[i] <= 1'b0;
      else if (srst_i)   full_q[i] <= 1'b0;
      else if (set_c)    full_q[i] <= 1'b1;
      else if (ack_v[i]) full_q[i] <= 1'b0;
    end

    AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_v[i] && !set_c && !srst_i) |=> !full_o[i]); // R7
  end

  // switching into a region still held by software
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                    ovr_q <= 1'b0;
    else if (srst_i)                                ovr_q <= 1'b0;
    else if (wrap_i && full_q[~sel_q] && !ack_v[~sel_q]) ovr_q <= 1'b1;
    else if (ack_ovr_i)                             ovr_q <= 1'b0;
  end

  assign act1_o  = ~sel_q;
  assign full_o  = full_q;
  assign ovr_o   = ovr_q;
  assign stall_o = full_q[sel_q];
  assign irq_o   = |(full_q & ien_v) | (ovr_q & ien_ovr_i);

  AST_SWAP_ON_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_i && !srst_i) |=> (act1_o != $past(act1_o))); // R5

  AST_OVR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_o && !ack_ovr_i && !srst_i) |=> ovr_o); // R8

endmodule

// File: rtl/pp_capture_ctrl.sv
module pp_capture_ctrl
  import pp_capture_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned SW        = 32,
  parameter int unsigned STEP      = 4,
  parameter int unsigned ALIGN_LSB = 6
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 reg_we_i,
  input  logic [REG_SEL_W-1:0] reg_addr_i,
  input  logic [AW-1:0]        reg_wdata_i,
  output logic [AW-1:0]        reg_rdata_o,
  input  logic                 smp_valid_i,
  input  logic [SW-1:0]        smp_data_i,
  output logic                 mem_we_o,
  output logic [AW-1:0]        mem_addr_o,
  output logic [SW-1:0]        mem_wdata_o,
  output logic                 irq_o
);

  ctrl_t         ctrl;
  strb_t         strb;
  stat_t         stat;
  logic [AW-1:0] base1, base2, size, offset;
  logic [1:0]    full;
  logic          act1, ovr, stall, wrap, accept;

  pp_regs #(.AW(AW), .ALIGN_LSB(ALIGN_LSB)) i_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .stat_i  (stat),
    .rdata_o (reg_rdata_o),
    .ctrl_o  (ctrl),
    .strb_o  (strb),
    .base1_o (base1),
    .base2_o (base2),
    .size_o  (size)
  );

  assign accept = ctrl.en && smp_valid_i && !stall;

  pp_addr_gen #(.AW(AW), .STEP(STEP)) i_addr_gen (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .srst_i   (strb.srst),
    .en_i     (ctrl.en),
    .accept_i (accept),
    .size_i   (size),
    .offset_o (offset),
    .wrap_o   (wrap)
  );

  pp_flags i_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .srst_i    (strb.srst),
    .wrap_i    (wrap),
    .ack1_i    (strb.ack1),
    .ack2_i    (strb.ack2),
    .ack_ovr_i (strb.ack_ovr),
    .ien1_i    (ctrl.ien1),
    .ien2_i    (ctrl.ien2),
    .ien_ovr_i (ctrl.ien_ovr),
    .act1_o    (act1),
    .full_o    (full),
    .ovr_o     (ovr),
    .stall_o   (stall),
    .irq_o     (irq_o)
  );

  assign stat = '{ovr: ovr, full2: full[1], full1: full[0], act1: act1};

  assign mem_we_o    = accept;
  assign mem_addr_o  = (act1 ? base1 : base2) + offset;
  assign mem_wdata_o = smp_data_i;

  AST_WRITE_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_addr_o[1:0] == 2'b00)); // R4

  AST_SRST_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strb.srst |=> (stat == 4'b0001 && !irq_o)); // R11

  AST_NO_WRITE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == SEL_CTRL && !reg_wdata_i[0]) |=> !mem_we_o); // R3

endmodule

// File: tb/test_pp_capture_ctrl.sv
`timescale 1ns/1ps
module test_pp_capture_ctrl;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        smp_valid_i = 1'b0;
  logic [31:0] smp_data_i = '0;
  logic        mem_we_o;
  logic [31:0] mem_addr_o;
  logic [31:0] mem_wdata_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] seed = 32'hA5000000;

  always #2 clk = ~clk;

  pp_capture_ctrl i_pp_capture_ctrl (
    .clk_i(clk), .rst_ni(rst_ni),
    .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o),
    .smp_valid_i(smp_valid_i), .smp_data_i(smp_data_i),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .irq_o(irq_o)
  );

  // reference model state
  logic [3:0]  m_ctrl;
  logic [31:0] m_base [2];
  logic [31:0] m_size, m_off;
  logic [1:0]  m_full;
  int          m_sel;
  logic        m_ovr;

  function automatic void m_reset();
    m_ctrl = '0; m_base[0] = '0; m_base[1] = '0; m_size = '0; m_off = '0;
    m_full = '0; m_sel = 0; m_ovr = 1'b0;
  endfunction

  function automatic logic [31:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return {28'b0, m_ctrl};
      3'd1: return m_base[0];
      3'd2: return m_base[1];
      3'd3: return m_size;
      3'd4: return {28'b0, m_ovr, m_full[1], m_full[0], (m_sel == 0)};
      default: return '0;
    endcase
  endfunction

  function automatic void chk(input string tag, input string what,
                              input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endfunction

  function automatic void m_update();
    logic ctrl_wr, a_ov, acc, wrapv;
    logic [1:0] ack, n_full;
    int oth;
    ctrl_wr = reg_we_i && reg_addr_i == 3'd0;
    if (ctrl_wr && reg_wdata_i[7]) begin
      m_reset();
      return;
    end
    ack   = {ctrl_wr && reg_wdata_i[5], ctrl_wr && reg_wdata_i[4]};
    a_ov  = ctrl_wr && reg_wdata_i[6];
    acc   = m_ctrl[0] && smp_valid_i && !m_full[m_sel];
    wrapv = acc && (m_off + 32'd4 >= m_size);
    oth   = 1 - m_sel;
    n_full = m_full;
    for (int i = 0; i < 2; i++) begin
      if (wrapv && m_sel == i) n_full[i] = 1'b1;
      else if (ack[i])         n_full[i] = 1'b0;
    end
    if (wrapv && m_full[oth] && !ack[oth]) m_ovr = 1'b1;
    else if (a_ov)                          m_ovr = 1'b0;
    if (!m_ctrl[0])  m_off = '0;
    else if (wrapv)  m_off = '0;
    else if (acc)    m_off = m_off + 32'd4;
    if (wrapv) m_sel = oth;
    m_full = n_full;
    if (reg_we_i) begin
      case (reg_addr_i)
        3'd0: m_ctrl = reg_wdata_i[3:0];
        3'd1: m_base[0] = reg_wdata_i & ~32'h3F;
        3'd2: m_base[1] = reg_wdata_i & ~32'h3F;
        3'd3: m_size = reg_wdata_i & ~32'h3F;
        default: ;
      endcase
    end
  endfunction

  // one cycle: compare combinational outputs, then advance the model
  task automatic step(input string tag);
    logic exp_we, exp_irq;
    #1;
    exp_we  = m_ctrl[0] && smp_valid_i && !m_full[m_sel];
    exp_irq = (m_full[0] & m_ctrl[1]) | (m_full[1] & m_ctrl[2]) | (m_ovr & m_ctrl[3]);
    chk(tag, "mem_we", {31'b0, mem_we_o}, {31'b0, exp_we});
    if (exp_we) begin
      chk(tag, "mem_addr", mem_addr_o, m_base[m_sel] + m_off);
      chk(tag, "mem_wdata", mem_wdata_o, smp_data_i);
    end
    chk("R6", "irq", {31'b0, irq_o}, {31'b0, exp_irq});
    chk(tag, "rdata", reg_rdata_o, m_read(reg_addr_i));
    @(posedge clk);
    m_update();
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d, input string tag);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    step(tag);
    reg_we_i = 1'b0; reg_wdata_i = '0;
  endtask

  task automatic rd(input logic [2:0] a, input string tag);
    reg_addr_i = a;
    step(tag);
  endtask

  task automatic samples(input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      smp_valid_i = 1'b1; smp_data_i = seed; seed = seed + 32'h00010003;
      step(tag);
    end
    smp_valid_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    m_reset();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset state
    rd(3'd4, "R1"); rd(3'd0, "R1"); rd(3'd1, "R1");
    // R2 alignment masking
    wr(3'd1, 32'h0000_103F, "R2"); wr(3'd2, 32'h0000_2011, "R2");
    wr(3'd3, 32'h0000_0045, "R2");
    rd(3'd1, "R2"); rd(3'd2, "R2"); rd(3'd3, "R2");
    // R3 disabled: samples ignored
    samples(4, "R3");
    rd(3'd4, "R3");
    // R4 fill region one, R5 switch
    wr(3'd0, 32'h7, "R12");
    samples(16, "R4");
    rd(3'd4, "R5");
    samples(8, "R5");
    wr(3'd0, 32'h17, "R7");
    rd(3'd4, "R7");
    samples(8, "R5");
    rd(3'd4, "R5");
    // R8 overrun on switch into unacknowledged region
    samples(16, "R8");
    rd(3'd4, "R8");
    samples(4, "R9");
    wr(3'd0, 32'h17, "R8");
    rd(3'd4, "R8");
    samples(3, "R9");
    wr(3'd0, 32'h27, "R9");
    samples(3, "R9");
    wr(3'd0, 32'h9, "R6");
    rd(3'd4, "R6");
    wr(3'd0, 32'h49, "R8");
    rd(3'd4, "R8");
    // R10 enable drop mid-region
    wr(3'd0, 32'h7, "R10");
    samples(5, "R10");
    wr(3'd0, 32'h6, "R10");
    samples(2, "R3");
    wr(3'd0, 32'h7, "R10");
    samples(1, "R10");
    rd(3'd4, "R10");
    // R7 fill and acknowledge of the same region in one cycle
    samples(14, "R7");
    reg_we_i = 1'b1; reg_addr_i = 3'd0; reg_wdata_i = 32'h37;
    smp_valid_i = 1'b1; smp_data_i = seed;
    step("R7");
    reg_we_i = 1'b0; reg_wdata_i = '0; smp_valid_i = 1'b0;
    rd(3'd4, "R7");
    // R11 soft reset
    wr(3'd0, 32'h80, "R11");
    rd(3'd4, "R11"); rd(3'd1, "R11"); rd(3'd3, "R11"); rd(3'd0, "R11");
    samples(2, "R11");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule